// File: doc/BRIEF.md
# Sliding-Window Code Occurrence Counter

This block builds a code-occurrence histogram of a converter's output while that converter is driven by a slow ramp. It does not keep one counter for every code. It keeps a small chain of saturating counters centred on an expected code C. C follows the ramp. Each time C steps, the chain shifts by one place and the count of the code that has just left the window is streamed out. An off-block analyser turns those counts into code widths.

After a start command, samples are ignored until the first valid one. That sample seeds C. Each later in-window sample is added to the counter for its offset from C. If a sample falls outside the window, a sticky failure flag is raised and the run stops. The run ends normally at the end-of-range sample. The counts still held for C and the codes behind it are then flushed out, and a done flag is raised. A direction input selects a rising or a falling ramp. Two configuration inputs say whether the converter provides underflow and overflow flags.

Top module: `code_window_hist`

## Requirements
- R1: After reset, and on the cycle after `start`, `cnt_valid`, `done` and `win_fail` are low and all counters are cleared.
- R2: After `start`, samples are ignored until the first valid one. For a rising ramp that is the first sample with `smp_uf` low when `use_uf` is 1, or else the first non-zero code. For a falling ramp it is the first sample with `smp_of` low when `use_of` is 1, or else the first code that is not all ones. That sample sets C to its own code and is counted once.
- R3: Every in-window sample increments exactly one counter: the one for its offset from C, where the offset runs from -2 to +2 and is measured along the ramp direction.
- R4: C steps one code along the ramp direction only after two consecutive valid samples both lie beyond C in that direction. The second of those samples is counted before the step. After a step, a new pair of samples is needed before the next step.
- R5: On each step, every count moves one place toward the trailing end. The count for code C-2 (C+2 on a falling ramp), including the sample just counted, appears on `cnt_data` with `cnt_valid` high for one cycle, on the clock edge that takes the step.
- R6: A sample with an offset outside -2..+2 sets `win_fail` and `done`. Both stay high until the next `start`, and no further counts are emitted.
- R7: The run ends at the end-of-range sample, which is not counted. For a rising ramp that is `smp_of` high when `use_of` is 1, or else the all-ones code. The three counts for C-2, C-1 and C (mirrored on a falling ramp) are then emitted on three consecutive cycles, and `done` rises with the last of them.
- R8: With `falling` high at `start`, the sense of the window is mirrored: C decrements, and the run ends at `smp_uf` high (when `use_uf` is 1) or at code zero.
- R9: A counter holds at 15 and does not wrap.
- R10: Cycles with `smp_valid` low change neither the counts, nor C, nor the pairing of consecutive samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new run; clears counts and flags |
| falling | input | 1 | Ramp direction for the run, captured at `start` (1 = falling) |
| use_uf | input | 1 | Converter provides an underflow flag |
| use_of | input | 1 | Converter provides an overflow flag |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_code | input | 6 | Converter output code |
| smp_uf | input | 1 | Underflow flag of the sample |
| smp_of | input | 1 | Overflow flag of the sample |
| cnt_valid | output | 1 | A completed code count is on `cnt_data` |
| cnt_data | output | 4 | Completed code count |
| win_fail | output | 1 | Sticky window-overflow failure |
| done | output | 1 | Run finished, normally or by failure |

## Verification
The bench builds the block with its default parameters: 6-bit codes, 4-bit counters and a half-width of two. With a 6-bit code, the all-ones end marker and the zero start marker are reachable in a few dozen samples. With 4-bit counters, saturation is reachable with twenty repeats of one code. With the narrow window, a jump of three codes is enough to trigger the failure path. Short ideal ramps in both directions, with and without the converter flags, give streams of counts that can be worked out by hand.

// File: rtl/code_window_hist.sv
module code_window_hist #(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 4,
  parameter int HALF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              falling,
  input  logic              use_uf,
  input  logic              use_of,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  input  logic              smp_uf,
  input  logic              smp_of,
  output logic              cnt_valid,
  output logic [CNT_W-1:0]  cnt_data,
  output logic              win_fail,
  output logic              done
);
  localparam int WIN = 2 * HALF + 1;
  localparam int RW  = CODE_W + 2;
  localparam int FW  = $clog2(HALF + 2);
  localparam logic [CODE_W-1:0]    CODE_TOP = '1;
  localparam logic [CNT_W-1:0]     CNT_TOP  = '1;
  localparam logic signed [RW-1:0] LIM      = RW'(HALF);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_RUN, S_FLUSH, S_DONE} st_t;

  st_t               st;
  logic [CNT_W-1:0]  slot_q [WIN];
  logic [CNT_W-1:0]  bump   [WIN];
  logic [CODE_W-1:0] c_q;
  logic              dn_q, gt_q;
  logic [FW-1:0]     fl_q;

  logic signed [RW-1:0] rel;
  logic [RW-1:0]        idx;
  logic in_win, gt, first_ok, end_hit, c_edge, adv;

  assign rel = dn_q ? ($signed({2'b00, c_q}) - $signed({2'b00, smp_code}))
                    : ($signed({2'b00, smp_code}) - $signed({2'b00, c_q}));
  assign idx      = rel + LIM;
  assign in_win   = (rel >= -LIM) && (rel <= LIM);
  assign gt       = !rel[RW-1] && (rel != '0);
  assign first_ok = dn_q ? (use_of ? !smp_of : (smp_code != CODE_TOP))
                         : (use_uf ? !smp_uf : (smp_code != '0));
  assign end_hit  = dn_q ? (use_uf ? smp_uf : (smp_code == '0))
                         : (use_of ? smp_of : (smp_code == CODE_TOP));
  assign c_edge   = dn_q ? (c_q == '0) : (c_q == CODE_TOP);
  assign adv      = gt && gt_q && !c_edge;

  always_comb begin
    for (int k = 0; k < WIN; k++) begin
      bump[k] = slot_q[k];
      if (idx == RW'(k) && slot_q[k] != CNT_TOP) bump[k] = slot_q[k] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      c_q       <= '0;
      dn_q      <= 1'b0;
      gt_q      <= 1'b0;
      fl_q      <= '0;
      win_fail  <= 1'b0;
      done      <= 1'b0;
      cnt_valid <= 1'b0;
      cnt_data  <= '0;
      for (int k = 0; k < WIN; k++) slot_q[k] <= '0;
    end else begin
      cnt_valid <= 1'b0;
      if (start) begin
        st       <= S_WAIT;
        dn_q     <= falling;
        gt_q     <= 1'b0;
        fl_q     <= '0;
        win_fail <= 1'b0;
        done     <= 1'b0;
        for (int k = 0; k < WIN; k++) slot_q[k] <= '0;
      end else begin
        case (st)
          S_WAIT:
            if (smp_valid && first_ok) begin
              if (end_hit) st <= S_FLUSH;
              else begin
                c_q          <= smp_code;
                slot_q[HALF] <= CNT_W'(1);
                st           <= S_RUN;
              end
            end
          S_RUN:
            if (smp_valid) begin
              if (end_hit) st <= S_FLUSH;
              else if (!in_win) begin
                win_fail <= 1'b1;
                done     <= 1'b1;
                st       <= S_DONE;
              end else if (adv) begin
                for (int k = 0; k < WIN - 1; k++) slot_q[k] <= bump[k+1];
                slot_q[WIN-1] <= '0;
                cnt_valid     <= 1'b1;
                cnt_data      <= bump[0];
                c_q           <= dn_q ? c_q - 1'b1 : c_q + 1'b1;
                gt_q          <= 1'b0;
              end else begin
                for (int k = 0; k < WIN; k++) slot_q[k] <= bump[k];
                gt_q <= gt;
              end
            end
          S_FLUSH: begin
            cnt_valid <= 1'b1;
            cnt_data  <= slot_q[0];
            for (int k = 0; k < WIN - 1; k++) slot_q[k] <= slot_q[k+1];
            slot_q[WIN-1] <= '0;
            fl_q <= fl_q + 1'b1;
            if (fl_q == FW'(HALF)) begin
              st   <= S_DONE;
              done <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAIT |-> !cnt_valid); // R2
  AST_C_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !start) |=> (c_q == $past(c_q) ||
      CODE_W'(($past(dn_q) ? $past(c_q) - c_q : c_q - $past(c_q))) == CODE_W'(1))); // R4
  AST_EMIT_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !start) |=> (cnt_valid == (c_q != $past(c_q)))); // R5
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (win_fail && !start) |=> win_fail); // R6
  AST_FAIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_fail) |-> done); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !cnt_valid); // R7
endmodule

// File: tb/code_window_hist_bench.sv
module code_window_hist_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, falling, use_uf, use_of;
  logic smp_valid, smp_uf, smp_of;
  logic [5:0] smp_code;
  logic cnt_valid, win_fail, done;
  logic [3:0] cnt_data;

  code_window_hist u_code_window_hist (
    .clk(clk), .rst_n(rst_n), .start(start), .falling(falling),
    .use_uf(use_uf), .use_of(use_of), .smp_valid(smp_valid),
    .smp_code(smp_code), .smp_uf(smp_uf), .smp_of(smp_of),
    .cnt_valid(cnt_valid), .cnt_data(cnt_data),
    .win_fail(win_fail), .done(done));

  int checks = 0;
  int errors = 0;
  int n_em = 0;
  int em [0:255];

  always @(negedge clk)
    if (rst_n && cnt_valid) begin
      if (n_em < 256) em[n_em] = int'(cnt_data);
      n_em++;
    end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(int code, bit v = 1'b1, bit uf = 1'b0, bit of = 1'b0);
    @(negedge clk);
    smp_valid = v; smp_code = code[5:0]; smp_uf = uf; smp_of = of;
  endtask

  task automatic rest(int n);
    @(negedge clk);
    smp_valid = 1'b0; smp_uf = 1'b0; smp_of = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic kick(bit dir);
    @(negedge clk);
    start = 1'b1; falling = dir; smp_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_seq(string req, int base, int exp[]);
    chk(req, n_em - base, exp.size());
    foreach (exp[i]) chk(req, em[base + i], exp[i]);
  endtask

  task automatic t_reset;
    chk("R1 reset cnt_valid", int'(cnt_valid), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset win_fail", int'(win_fail), 0);
  endtask

  task automatic t_rise_plain; // R3 R5 R7 R10
    int base;
    use_uf = 1'b0; use_of = 1'b0;
    kick(1'b0);
    base = n_em;
    repeat (3) put(0);
    for (int c = 1; c <= 5; c++)
      for (int j = 0; j < 4; j++) begin
        put(c);
        if (c == 2 && j == 0) repeat (3) put(40, 1'b0);
      end
    put(63);
    rest(6);
    expect_seq("R5 R7 rising counts", base, '{0, 0, 4, 4, 4, 4, 4});
    chk("R7 done after end", int'(done), 1);
    chk("R10 invalid cycles ignored", int'(win_fail), 0);
  endtask

  task automatic t_rise_flags; // R2 R7
    int base;
    use_uf = 1'b1; use_of = 1'b1;
    kick(1'b0);
    base = n_em;
    put(0, 1'b1, 1'b1); put(0, 1'b1, 1'b1);
    for (int c = 0; c <= 3; c++) repeat (3) put(c);
    put(63, 1'b1, 1'b0, 1'b1);
    rest(6);
    expect_seq("R2 R7 flagged rising counts", base, '{0, 0, 3, 3, 3, 3});
    chk("R7 done with flags", int'(done), 1);
  endtask

  task automatic t_no_pair; // R4
    int base;
    use_uf = 1'b0; use_of = 1'b0;
    kick(1'b0);
    base = n_em;
    put(1); put(2); put(1); put(2); put(1); put(63);
    rest(6);
    expect_seq("R4 alternating samples do not step", base, '{0, 0, 3});
  endtask

  task automatic t_saturate; // R9
    int base;
    kick(1'b0);
    base = n_em;
    repeat (20) put(1);
    put(63);
    rest(6);
    expect_seq("R9 saturating count", base, '{0, 0, 15});
  endtask

  task automatic t_window_fail; // R6 R1
    int base;
    kick(1'b0);
    base = n_em;
    put(1); put(1); put(5);
    rest(2);
    chk("R6 win_fail set", int'(win_fail), 1);
    chk("R6 done on failure", int'(done), 1);
    put(2); put(2); put(2); put(63);
    rest(6);
    chk("R6 no counts after failure", n_em - base, 0);
    chk("R6 win_fail sticky", int'(win_fail), 1);
    kick(1'b0);
    chk("R1 start clears win_fail", int'(win_fail), 0);
    chk("R1 start clears done", int'(done), 0);
  endtask

  task automatic t_falling; // R8
    int base;
    use_uf = 1'b0; use_of = 1'b0;
    kick(1'b1);
    base = n_em;
    put(63); put(63);
    for (int c = 10; c >= 7; c--) repeat (3) put(c);
    put(0);
    rest(6);
    expect_seq("R8 falling counts", base, '{0, 0, 3, 3, 3, 3});
    chk("R8 done at zero", int'(done), 1);
    chk("R8 no failure", int'(win_fail), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; falling = 1'b0; use_uf = 1'b0; use_of = 1'b0;
    smp_valid = 1'b0; smp_code = '0; smp_uf = 1'b0; smp_of = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise_plain();
    t_rise_flags();
    t_no_pair();
    t_saturate();
    t_window_fail();
    t_falling();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule